// File: doc/BRIEF.md
# Phase Build-Out Unit with Slew-Limited Realignment

This unit sits between the phase detector and the loop filter of a digital PLL. When the reference input or the loop mode changes, the phase offset between the newly selected reference and the running output would otherwise reach the loop filter as a step. The output clock would then jump. The unit prevents this. On a rearrangement strobe it latches the present raw phase error as a build-out value. From then on it subtracts that value from every raw error, so the loop sees no step and the output phase is held.

Build-out values from many switches can add up. A realignment command removes the accumulated offset. The command picks as its target the multiple of the reference period that lies nearest to the current build-out, which is the nearest reference edge. The unit then walks the build-out toward that target. Each walk step happens only on a phase sample strobe, which marks one input clock cycle, and moves by no more than a programmable slew limit. A busy flag is high while the walk runs. It drops on the step that lands on the target. A new rearrangement during the walk ends the walk and captures a fresh offset.

Top module: `phase_buildout`

## Requirements
- R1: While reset is low and on the edge after it, build_out is 0 and ramp_busy is 0.
- R2: On an edge where rearr is 1, build_out becomes the sign-extended raw_err and ramp_busy becomes 0. This takes priority over a command and over a walk step in the same cycle.
- R3: corr_err equals raw_err minus build_out at all times, in ERR_W+2 signed bits.
- R4: build_out keeps its value on every edge that has neither a capture nor a walk step. Only a capture or a walk step changes it.
- R5: A realign_cmd with rearr low and ramp_busy low sets ramp_busy on the next edge. It fixes the target as build_out rounded to the nearest multiple of 2^PER_LOG2, with a tie rounded upward, for example 512 to 1024 and -700 to -1024.
- R6: A walk step happens only on an edge where ramp_busy and phase_vld are 1 and rearr is 0. It moves build_out toward the target by at most slew_lim, taken as unsigned.
- R7: When the remaining distance is at most slew_lim, the step sets build_out to the target and clears ramp_busy on that same edge.
- R8: A realign_cmd is ignored while ramp_busy is 1 or when rearr is 1. The target stays unchanged, and with rearr high no walk starts.
- R9: With slew_lim at 0 and a nonzero distance left, a walk step leaves build_out unchanged and ramp_busy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_vld | input | 1 | One pulse per input clock cycle; enables a walk step |
| raw_err | input | ERR_W | Signed raw phase error from the detector |
| rearr | input | 1 | Reference or mode rearrangement strobe |
| realign_cmd | input | 1 | Request to realign to the nearest reference edge |
| slew_lim | input | SLEW_W | Largest build-out change per walk step, unsigned |
| corr_err | output | ERR_W+2 | Signed corrected error to the loop filter |
| build_out | output | ERR_W+1 | Signed stored build-out value |
| ramp_busy | output | 1 | High while a realignment walk is running |

## Verification
The checker assumes that rearr and realign_cmd are synchronous single-cycle strobes, and that slew_lim is stable on the edge where a walk step is taken. The stimulus changes every input only at the falling edge, and it changes slew_lim in the same cycle as a step only in rows where the expected step is worked out with the new value. Raw errors stay well inside the ERR_W range, so rounding to the nearest edge never leaves the build-out width. The stimulus also covers the tie case and a walk toward a negative target.

// File: rtl/phase_buildout_pkg.sv
package phase_buildout_pkg;

  typedef logic signed [31:0] wide_t;

  // Round to nearest multiple of 2**sh, ties upward.
  function automatic wide_t nearest_edge(input wide_t v, input int sh);
    wide_t half;
    half = wide_t'(1) <<< (sh - 1);
    return ((v + half) >>> sh) <<< sh;
  endfunction

  // Move cur toward tgt by no more than lim.
  function automatic wide_t slew_toward(input wide_t cur, input wide_t tgt, input wide_t lim);
    wide_t diff;
    diff = tgt - cur;
    if (diff > lim)       return cur + lim;
    else if (diff < -lim) return cur - lim;
    else                  return tgt;
  endfunction

endpackage

// File: rtl/phase_buildout_target.sv
module phase_buildout_target
  import phase_buildout_pkg::*;
#(
  parameter int BO_W     = 17,
  parameter int PER_LOG2 = 10
) (
  input  logic signed [BO_W-1:0] cur_bo,
  output logic signed [BO_W-1:0] edge_tgt
);
  wide_t rounded;
  always_comb begin
    rounded  = nearest_edge(32'(cur_bo), PER_LOG2);
    edge_tgt = BO_W'(rounded);
  end
endmodule

// File: rtl/phase_buildout_ramp.sv
module phase_buildout_ramp
  import phase_buildout_pkg::*;
#(
  parameter int BO_W   = 17,
  parameter int SLEW_W = 8
) (
  input  logic signed [BO_W-1:0] cur_bo,
  input  logic signed [BO_W-1:0] tgt_bo,
  input  logic [SLEW_W-1:0]      lim,
  output logic signed [BO_W-1:0] next_bo,
  output logic                   at_tgt
);
  wide_t stepped;
  always_comb begin
    stepped = slew_toward(32'(cur_bo), 32'(tgt_bo), wide_t'(32'(lim)));
    next_bo = BO_W'(stepped);
    at_tgt  = (next_bo == tgt_bo);
  end
endmodule

// File: rtl/phase_buildout_correct.sv
module phase_buildout_correct #(
  parameter int ERR_W = 16,
  parameter int BO_W  = 17
) (
  input  logic signed [ERR_W-1:0] raw,
  input  logic signed [BO_W-1:0]  bo,
  output logic signed [ERR_W+1:0] corr
);
  localparam int CW = ERR_W + 2;
  always_comb corr = CW'(raw) - CW'(bo);
endmodule

// File: rtl/phase_buildout.sv
module phase_buildout #(
  parameter int ERR_W    = 16,
  parameter int SLEW_W   = 8,
  parameter int PER_LOG2 = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phase_vld,
  input  logic signed [ERR_W-1:0] raw_err,
  input  logic                    rearr,
  input  logic                    realign_cmd,
  input  logic [SLEW_W-1:0]       slew_lim,
  output logic signed [ERR_W+1:0] corr_err,
  output logic signed [ERR_W:0]   build_out,
  output logic                    ramp_busy
);
  localparam int BO_W = ERR_W + 1;

  logic signed [BO_W-1:0] bo_q, tgt_q, edge_tgt, ramp_next;
  logic                   busy_q, ramp_done;

  // named internal events
  logic cap_evt, start_evt, step_evt, done_evt;
  assign cap_evt   = rearr;
  assign start_evt = realign_cmd && !rearr && !busy_q;
  assign step_evt  = busy_q && phase_vld && !rearr;
  assign done_evt  = step_evt && ramp_done;

  phase_buildout_target #(.BO_W(BO_W), .PER_LOG2(PER_LOG2)) u_target (
    .cur_bo(bo_q), .edge_tgt(edge_tgt)
  );

  phase_buildout_ramp #(.BO_W(BO_W), .SLEW_W(SLEW_W)) u_ramp (
    .cur_bo(bo_q), .tgt_bo(tgt_q), .lim(slew_lim),
    .next_bo(ramp_next), .at_tgt(ramp_done)
  );

  phase_buildout_correct #(.ERR_W(ERR_W), .BO_W(BO_W)) u_correct (
    .raw(raw_err), .bo(bo_q), .corr(corr_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo_q   <= '0;
      tgt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cap_evt) begin
      bo_q   <= BO_W'(raw_err);
      busy_q <= 1'b0;
    end else if (start_evt) begin
      tgt_q  <= edge_tgt;
      busy_q <= 1'b1;
    end else if (step_evt) begin
      bo_q <= ramp_next;
      if (done_evt) busy_q <= 1'b0;
    end
  end

  assign build_out = bo_q;
  assign ramp_busy = busy_q;
endmodule

// File: rtl/phase_buildout_chk.sv
module phase_buildout_chk #(
  parameter int ERR_W    = 16,
  parameter int SLEW_W   = 8,
  parameter int PER_LOG2 = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    phase_vld,
  input logic signed [ERR_W-1:0] raw_err,
  input logic                    rearr,
  input logic                    realign_cmd,
  input logic [SLEW_W-1:0]       slew_lim,
  input logic signed [ERR_W:0]   build_out,
  input logic                    ramp_busy
);
  localparam int BO_W = ERR_W + 1;

  logic signed [BO_W-1:0] raw_ext;
  assign raw_ext = BO_W'(raw_err);

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearr |=> (build_out == $past(raw_ext)) && !ramp_busy);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearr && !(ramp_busy && phase_vld)) |=> $stable(build_out));

  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_busy && phase_vld && !rearr) |=>
      ((build_out >= $past(build_out) ? build_out - $past(build_out)
                                      : $past(build_out) - build_out)
       <= BO_W'($past(slew_lim))));

  // R7
  done_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ramp_busy) && !$past(rearr)) |-> (build_out[PER_LOG2-1:0] == '0));

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_busy) |-> $past(realign_cmd));
endmodule

bind phase_buildout phase_buildout_chk #(.ERR_W(ERR_W), .SLEW_W(SLEW_W), .PER_LOG2(PER_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .raw_err(raw_err),
  .rearr(rearr), .realign_cmd(realign_cmd), .slew_lim(slew_lim),
  .build_out(build_out), .ramp_busy(ramp_busy)
);

// File: tb/tb_phase_buildout.sv
module tb_phase_buildout;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 16;
  localparam int SLEW_W = 8;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_vld = 1'b0, rearr = 1'b0, realign_cmd = 1'b0;
  logic signed [ERR_W-1:0] raw_err = '0;
  logic [SLEW_W-1:0] slew_lim = '0;
  logic signed [ERR_W+1:0] corr_err;
  logic signed [ERR_W:0] build_out;
  logic ramp_busy;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_buildout dut (
    .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .raw_err(raw_err),
    .rearr(rearr), .realign_cmd(realign_cmd), .slew_lim(slew_lim),
    .corr_err(corr_err), .build_out(build_out), .ramp_busy(ramp_busy)
  );

  typedef struct packed {
    logic rr;
    logic cmd;
    logic vld;
    logic signed [15:0] raw;
    logic [7:0] slew;
    logic signed [16:0] bo;
    logic busy;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 1'b0, 1'b0,  16'sd300,   8'd0,  17'sd300, 1'b0}, // R2 capture
    '{1'b0, 1'b0, 1'b1,  16'sd310,   8'd0,  17'sd300, 1'b0}, // R4 hold
    '{1'b0, 1'b1, 1'b0,  16'sd310, 8'd100,  17'sd300, 1'b1}, // R5 start, target 0
    '{1'b0, 1'b0, 1'b1,  16'sd310, 8'd100,  17'sd200, 1'b1}, // R6 step
    '{1'b0, 1'b0, 1'b0,  16'sd310, 8'd100,  17'sd200, 1'b1}, // R6 no vld no step
    '{1'b0, 1'b0, 1'b1,  16'sd310, 8'd100,  17'sd100, 1'b1}, // R6
    '{1'b0, 1'b0, 1'b1,  16'sd310, 8'd100,    17'sd0, 1'b0}, // R7 lands
    '{1'b1, 1'b0, 1'b0, -16'sd700,   8'd0, -17'sd700, 1'b0}, // R2 negative
    '{1'b0, 1'b1, 1'b0, -16'sd700, 8'd250, -17'sd700, 1'b1}, // R5 target -1024
    '{1'b0, 1'b0, 1'b1, -16'sd700, 8'd250, -17'sd950, 1'b1}, // R6 downward
    '{1'b1, 1'b0, 1'b1,   16'sd40, 8'd250,   17'sd40, 1'b0}, // R2 stops walk
    '{1'b1, 1'b1, 1'b0,   16'sd50, 8'd250,   17'sd50, 1'b0}, // R8 cmd with rearr
    '{1'b0, 1'b0, 1'b1,   16'sd50, 8'd250,   17'sd50, 1'b0}, // R8 no walk started
    '{1'b0, 1'b1, 1'b0,   16'sd50,   8'd0,   17'sd50, 1'b1}, // R5
    '{1'b0, 1'b0, 1'b1,   16'sd50,   8'd0,   17'sd50, 1'b1}, // R9 frozen
    '{1'b0, 1'b0, 1'b1,   16'sd50,  8'd60,    17'sd0, 1'b0}, // R7
    '{1'b1, 1'b0, 1'b0,  16'sd512,   8'd0,  17'sd512, 1'b0}, // R2
    '{1'b0, 1'b1, 1'b0,  16'sd512, 8'd600 - 8'd0, 17'sd512, 1'b1}, // R5 tie up
    '{1'b0, 1'b0, 1'b1,  16'sd512, 8'd255,  17'sd767, 1'b1}, // R6 toward 1024
    '{1'b1, 1'b0, 1'b0, -16'sd100,   8'd0, -17'sd100, 1'b0}, // R2
    '{1'b0, 1'b1, 1'b0, -16'sd100,  8'd30, -17'sd100, 1'b1}, // R5 target 0
    '{1'b0, 1'b1, 1'b1, -16'sd100,  8'd30,  -17'sd70, 1'b1}  // R8 cmd while busy
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic v,
                       input logic signed [15:0] raw, input logic [7:0] s);
    @(negedge clk);
    rearr = r; realign_cmd = c; phase_vld = v; raw_err = raw; slew_lim = s;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_corr(input string req);
    chk(req, "corr_err", corr_err, longint'(raw_err) - longint'(build_out));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    raw_err = 16'sd123;
    repeat (3) @(posedge clk);
    #1;
    // R1 state during reset
    chk("R1", "build_out", build_out, 0);
    chk("R1", "ramp_busy", ramp_busy, 0);
    chk_corr("R3");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rr, VECS[i].cmd, VECS[i].vld, VECS[i].raw, VECS[i].slew);
      chk($sformatf("vec%0d R2/R4-R9", i), "build_out", build_out, longint'(VECS[i].bo));
      chk($sformatf("vec%0d R5/R7", i), "ramp_busy", ramp_busy, longint'(VECS[i].busy));
      chk_corr($sformatf("vec%0d R3", i));
    end

    // R7: finish the walk from 767 toward 1024? Walk from -70 toward 0 with 30/step
    drive(0, 0, 1, -16'sd100, 8'd30);
    chk("R6", "build_out", build_out, -40);
    drive(0, 0, 1, -16'sd100, 8'd30);
    chk("R6", "build_out", build_out, -10);
    drive(0, 0, 1, -16'sd100, 8'd30);
    chk("R7", "build_out", build_out, 0);
    chk("R7", "ramp_busy", ramp_busy, 0);

    // R9: several frozen steps
    drive(1, 0, 0, 16'sd200, 8'd0);
    drive(0, 1, 0, 16'sd200, 8'd0);
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 1, 16'sd200, 8'd0);
      chk("R9", "build_out", build_out, 200);
      chk("R9", "ramp_busy", ramp_busy, 1);
    end

    // R1: reset in the middle of a walk
    drive(0, 0, 1, 16'sd200, 8'd50);
    chk("R6", "build_out", build_out, 150);
    @(negedge clk);
    rst_n = 1'b0; phase_vld = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", "build_out", build_out, 0);
    chk("R1", "ramp_busy", ramp_busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 1, 16'sd200, 8'd50);
    chk("R1", "build_out after reset", build_out, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule